// File: doc/BRIEF.md
# Aligned Vector Store Execution Unit

This unit carries out one 128-bit vector store. It takes a 32-bit instruction word that may arrive in either of two encodings. Both encodings lead to the same store path. The unit pulls out a vector source index and two general-register indexes, and it reads the operands through combinational register-file read ports that the surrounding core provides. It then forms a 16-byte-aligned address and emits the sixteen data bytes one per clock through a byte-wide memory write port.

Before the first byte goes out, the unit compares the aligned address against an outstanding load reservation and, on a match, pulses a kill strobe so the owner can drop the reservation. When the last byte has been written, a one-cycle completion pulse presents the next program counter. A word that matches neither encoding gets a one-cycle illegal flag and changes nothing else. Instruction bit 0 is the most significant bit of the word, so big-endian bit k sits at `instr_i[31-k]`.

Top module: `vstore_exec`

## Requirements
- R1: Basic form: the store is recognised when bits 0–5 equal 31 and bits 21–30 equal 487, with bit 31 ignored. The 5-bit vector source index comes from bits 6–10, and the upper two index bits are zero.
- R2: Wide form: the store is recognised when bits 0–5 equal 4 and bits 21–27 equal 60. The 7-bit vector index is {bits 28–29, bits 6–10}, and bits 30–31 are ignored.
- R3: In both forms the base register index sits in bits 11–15 and the offset register index in bits 16–20. A base index of 0 makes the base operand the constant zero, whatever register 0 holds.
- R4: The store address is base plus offset under wrap-around 64-bit addition. The low four bits are then forced to zero and the result is cut to 32 bits. No alignment fault exists.
- R5: Exactly 16 byte writes take place on consecutive clocks at addresses base+0 through base+15. The byte at base+i is vector bits [127-8i -: 8], so the most significant byte goes first.
- R6: When `resv_en_i` and `resv_valid_i` are both high and the reserved address lies in the same 16-byte granule as the store, `resv_kill_o` pulses for one cycle. That cycle is the one just before the first byte write.
- R7: `resv_kill_o` stays low when tracking is disabled, when no reservation is held, or when the granule differs.
- R8: `done_o` pulses for one cycle, in the cycle after the last byte write, with `next_pc_o` equal to the accepted `pc_i` plus 4.
- R9: A word with `start_i` high while `ready_o` is high that matches neither form raises `illegal_o` for exactly the next cycle. It causes no memory write and no kill, and `ready_o` stays high.
- R10: `busy_o` is high in exactly the 16 write cycles. `start_i` has no effect while `ready_o` is low.
- R11: After a synchronous reset, `ready_o` is 1 and `busy_o`, `done_o`, `illegal_o`, `mem_we_o` and `resv_kill_o` are all 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Offer an instruction (taken when ready_o is high) |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the offered instruction |
| ready_o | output | 1 | Unit idle and able to accept |
| busy_o | output | 1 | High during the byte write cycles |
| illegal_o | output | 1 | One-cycle flag for an unrecognised word |
| vrf_idx_o | output | 7 | Vector register read index |
| vrf_data_i | input | 128 | Vector register read data |
| gpr_a_idx_o | output | 5 | Base register read index |
| gpr_a_data_i | input | 64 | Base register read data |
| gpr_b_idx_o | output | 5 | Offset register read index |
| gpr_b_data_i | input | 64 | Offset register read data |
| resv_en_i | input | 1 | Reservation tracking enabled |
| resv_valid_i | input | 1 | A reservation is held |
| resv_addr_i | input | 32 | Reserved address |
| resv_kill_o | output | 1 | Drop the reservation (one cycle) |
| mem_we_o | output | 1 | Byte write strobe |
| mem_addr_o | output | 32 | Byte write address |
| mem_wdata_o | output | 8 | Byte write data |
| done_o | output | 1 | One-cycle completion pulse |
| next_pc_o | output | 32 | Next program counter, valid with done_o |

## Verification
Take the clock edge that accepts a start as edge 0. The operand read and any reservation kill show up in the cycle after edge 0. The sixteen byte writes fill the next sixteen cycles. The done pulse comes in the cycle after that, and an illegal flag appears in the cycle right after edge 0. Every scenario task counts cycles from the accepting edge and samples on the falling edge of each cycle. It therefore compares each output in exactly the cycle it is due, and checks it is absent in the cycles on either side.

// File: rtl/vstore_pkg.sv
package vstore_pkg;

    localparam int INSTR_W     = 32;
    localparam int GPR_W       = 64;
    localparam int ADDR_W      = 32;
    localparam int VEC_BYTES   = 16;
    localparam int VEC_W       = VEC_BYTES * 8;
    localparam int LANE_SEL_W  = $clog2(VEC_BYTES);
    localparam int VREG_IDX_W  = 7;
    localparam int GREG_IDX_W  = 5;
    localparam int PC_STEP     = 4;

    localparam logic [5:0] OPC_BASIC = 6'd31;
    localparam logic [9:0] XO_BASIC  = 10'd487;
    localparam logic [5:0] OPC_WIDE  = 6'd4;
    localparam logic [6:0] XO_WIDE   = 7'd60;

    typedef enum logic [1:0] {
        FMT_NONE,
        FMT_BASIC,
        FMT_WIDE
    } fmt_e;

    typedef struct packed {
        fmt_e                    fmt;
        logic [VREG_IDX_W-1:0]   vsrc;
        logic [GREG_IDX_W-1:0]   ra;
        logic [GREG_IDX_W-1:0]   rb;
    } dec_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } state_e;

    // Big-endian bit k of the word sits at w[31-k].
    function automatic dec_t decode_word(input logic [INSTR_W-1:0] w);
        dec_t d;
        d.fmt  = FMT_NONE;
        d.vsrc = {2'b00, w[25:21]};
        d.ra   = w[20:16];
        d.rb   = w[15:11];
        if (w[31:26] == OPC_BASIC && w[10:1] == XO_BASIC) begin
            d.fmt = FMT_BASIC;
        end else if (w[31:26] == OPC_WIDE && w[10:4] == XO_WIDE) begin
            d.fmt  = FMT_WIDE;
            d.vsrc = {w[3:2], w[25:21]};
        end
        return d;
    endfunction

    function automatic logic [ADDR_W-1:0] aligned_ea(
        input logic [GPR_W-1:0] base,
        input logic [GPR_W-1:0] off
    );
        logic [GPR_W-1:0] sum;
        sum = base + off;
        return ADDR_W'(sum) & ~ADDR_W'(VEC_BYTES - 1);
    endfunction

endpackage

// File: rtl/vstore_decode.sv
module vstore_decode
    import vstore_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output dec_t               dec_o,
    output logic               legal_o
);
    always_comb begin
        dec_o   = decode_word(instr_i);
        legal_o = (dec_o.fmt != FMT_NONE);
    end
endmodule

// File: rtl/vstore_agu.sv
module vstore_agu
    import vstore_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int DW   = GPR_W,
    parameter int IW   = GREG_IDX_W,
    parameter int GRAN = VEC_BYTES
) (
    input  logic [IW-1:0] ra_idx_i,
    input  logic [DW-1:0] base_i,
    input  logic [DW-1:0] off_i,
    input  logic          resv_en_i,
    input  logic          resv_valid_i,
    input  logic [AW-1:0] resv_addr_i,
    output logic [AW-1:0] ea_o,
    output logic          hit_o
);
    localparam logic [AW-1:0] GRAN_MASK = ~AW'(GRAN - 1);

    logic [DW-1:0] base_eff;

    always_comb begin
        base_eff = (ra_idx_i == '0) ? '0 : base_i;
        ea_o     = aligned_ea(base_eff, off_i);
        hit_o    = resv_en_i && resv_valid_i &&
                   ((resv_addr_i & GRAN_MASK) == ea_o);
    end
endmodule

// File: rtl/vstore_seq.sv
module vstore_seq
    import vstore_pkg::*;
#(
    parameter int NBYTES = VEC_BYTES,
    localparam int CW    = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          legal_i,
    output logic          accept_o,
    output logic          ready_o,
    output logic          rd_phase_o,
    output logic          wr_phase_o,
    output logic          done_o,
    output logic          illegal_o,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] LAST = CW'(NBYTES - 1);

    state_e        state_q;
    logic [CW-1:0] cnt_q;
    logic          illegal_q;

    always_comb begin
        ready_o    = (state_q == ST_IDLE);
        accept_o   = ready_o && start_i && legal_i;
        rd_phase_o = (state_q == ST_READ);
        wr_phase_o = (state_q == ST_WRITE);
        done_o     = (state_q == ST_DONE);
        illegal_o  = illegal_q;
        cnt_o      = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (legal_i) state_q   <= ST_READ;
                        else         illegal_q <= 1'b1;
                    end
                end
                ST_READ: begin
                    cnt_q   <= '0;
                    state_q <= ST_WRITE;
                end
                ST_WRITE: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vstore_exec.sv
module vstore_exec
    import vstore_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [INSTR_W-1:0]    instr_i,
    input  logic [ADDR_W-1:0]     pc_i,
    output logic                  ready_o,
    output logic                  busy_o,
    output logic                  illegal_o,
    output logic [VREG_IDX_W-1:0] vrf_idx_o,
    input  logic [VEC_W-1:0]      vrf_data_i,
    output logic [GREG_IDX_W-1:0] gpr_a_idx_o,
    input  logic [GPR_W-1:0]      gpr_a_data_i,
    output logic [GREG_IDX_W-1:0] gpr_b_idx_o,
    input  logic [GPR_W-1:0]      gpr_b_data_i,
    input  logic                  resv_en_i,
    input  logic                  resv_valid_i,
    input  logic [ADDR_W-1:0]     resv_addr_i,
    output logic                  resv_kill_o,
    output logic                  mem_we_o,
    output logic [ADDR_W-1:0]     mem_addr_o,
    output logic [7:0]            mem_wdata_o,
    output logic                  done_o,
    output logic [ADDR_W-1:0]     next_pc_o
);
    dec_t                   dec;
    logic                   legal;
    logic                   accept;
    logic                   rd_phase;
    logic                   wr_phase;
    logic [LANE_SEL_W-1:0]  cnt;
    logic [ADDR_W-1:0]      ea;
    logic                   hit;

    logic [VREG_IDX_W-1:0]  vsrc_q;
    logic [GREG_IDX_W-1:0]  ra_q;
    logic [GREG_IDX_W-1:0]  rb_q;
    logic [ADDR_W-1:0]      pc_q;
    logic [ADDR_W-1:0]      ea_q;
    logic [VEC_W-1:0]       vec_q;

    vstore_decode u_decode (
        .instr_i (instr_i),
        .dec_o   (dec),
        .legal_o (legal)
    );

    vstore_seq #(.NBYTES(VEC_BYTES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .legal_i    (legal),
        .accept_o   (accept),
        .ready_o    (ready_o),
        .rd_phase_o (rd_phase),
        .wr_phase_o (wr_phase),
        .done_o     (done_o),
        .illegal_o  (illegal_o),
        .cnt_o      (cnt)
    );

    vstore_agu u_agu (
        .ra_idx_i     (ra_q),
        .base_i       (gpr_a_data_i),
        .off_i        (gpr_b_data_i),
        .resv_en_i    (resv_en_i),
        .resv_valid_i (resv_valid_i),
        .resv_addr_i  (resv_addr_i),
        .ea_o         (ea),
        .hit_o        (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vsrc_q <= '0;
            ra_q   <= '0;
            rb_q   <= '0;
            pc_q   <= '0;
            ea_q   <= '0;
            vec_q  <= '0;
        end else begin
            if (accept) begin
                vsrc_q <= dec.vsrc;
                ra_q   <= dec.ra;
                rb_q   <= dec.rb;
                pc_q   <= pc_i;
            end
            if (rd_phase) begin
                ea_q  <= ea;
                vec_q <= vrf_data_i;
            end else if (wr_phase) begin
                vec_q <= vec_q << 8;
            end
        end
    end

    always_comb begin
        vrf_idx_o   = vsrc_q;
        gpr_a_idx_o = ra_q;
        gpr_b_idx_o = rb_q;
        resv_kill_o = rd_phase && hit;
        busy_o      = wr_phase;
        mem_we_o    = wr_phase;
        mem_addr_o  = {ea_q[ADDR_W-1:LANE_SEL_W], cnt};
        mem_wdata_o = vec_q[VEC_W-1 -: 8];
        next_pc_o   = pc_q + ADDR_W'(PC_STEP);
    end
endmodule

// File: rtl/vstore_exec_chk.sv
module vstore_exec_chk
    import vstore_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy_o,
    input logic              illegal_o,
    input logic              resv_en_i,
    input logic              resv_valid_i,
    input logic              resv_kill_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              done_o
);
    AST_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> busy_o); // R10

    AST_FIRST_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o && !$past(mem_we_o)) |-> (mem_addr_o[LANE_SEL_W-1:0] == '0)); // R4

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) + 1'b1)); // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8

    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(mem_we_o)); // R8

    AST_KILL_BEFORE_WRITE: assert property (@(posedge clk) disable iff (rst)
        resv_kill_o |=> mem_we_o); // R6

    AST_KILL_NEEDS_RESV: assert property (@(posedge clk) disable iff (rst)
        resv_kill_o |-> (resv_en_i && resv_valid_i)); // R7

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!mem_we_o && !resv_kill_o && !busy_o)); // R9
endmodule

bind vstore_exec vstore_exec_chk u_chk (.*);

// File: tb/vstore_exec_bench.sv
`timescale 1ns/1ps
module vstore_exec_bench;
    import vstore_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic                  start_i = 1'b0;
    logic [31:0]           instr_i = '0;
    logic [31:0]           pc_i = '0;
    logic                  ready_o, busy_o, illegal_o;
    logic [6:0]            vrf_idx_o;
    logic [127:0]          vrf_data_i;
    logic [4:0]            gpr_a_idx_o, gpr_b_idx_o;
    logic [63:0]           gpr_a_data_i, gpr_b_data_i;
    logic                  resv_en_i = 1'b0;
    logic                  resv_valid_i = 1'b0;
    logic [31:0]           resv_addr_i = '0;
    logic                  resv_kill_o;
    logic                  mem_we_o;
    logic [31:0]           mem_addr_o;
    logic [7:0]            mem_wdata_o;
    logic                  done_o;
    logic [31:0]           next_pc_o;

    logic [63:0]  gpr [32];
    logic [127:0] vrf [128];

    assign vrf_data_i   = vrf[vrf_idx_o];
    assign gpr_a_data_i = gpr[gpr_a_idx_o];
    assign gpr_b_data_i = gpr[gpr_b_idx_o];

    int n_chk  = 0;
    int n_fail = 0;

    vstore_exec u_vstore_exec (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_basic(input int vs, input int ra, input int rb);
        return {6'd31, 5'(vs), 5'(ra), 5'(rb), 10'd487, 1'b0};
    endfunction

    function automatic logic [31:0] enc_wide(input int vs, input int ra, input int rb);
        logic [6:0] v;
        v = 7'(vs);
        return {6'd4, v[4:0], 5'(ra), 5'(rb), 7'd60, v[6:5], 2'b11};
    endfunction

    // Drive one store and check every cycle from the accepting edge.
    task automatic run_store(input logic [31:0] w, input logic [31:0] pc,
                             input int vs, input logic [31:0] ea,
                             input bit kill_exp, input string tag, input bit poke);
        logic [127:0] v;
        bit addr_ok, data_ok, busy_ok;
        v = vrf[vs];
        addr_ok = 1; data_ok = 1; busy_ok = 1;
        @(negedge clk);
        start_i = 1'b1; instr_i = w; pc_i = pc;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        // cycle 1: operand read, kill strobe
        chk(resv_kill_o == kill_exp, kill_exp ? "R6" : "R7", {tag, " kill strobe"},
            128'(resv_kill_o), 128'(kill_exp));
        chk(!busy_o && !mem_we_o && !ready_o, "R10", {tag, " no write in read cycle"},
            128'({busy_o, mem_we_o, ready_o}), 128'(0));
        for (int i = 0; i < 16; i++) begin
            if (poke && i == 3) begin
                start_i = 1'b1; instr_i = enc_basic(1, 2, 3);
            end
            @(negedge clk);
            if (poke && i == 4) start_i = 1'b0;
            if (!(mem_we_o && busy_o)) busy_ok = 0;
            if (mem_addr_o != ea + 32'(i)) begin
                addr_ok = 0;
                $display("  addr byte %0d: %0h vs %0h", i, mem_addr_o, ea + 32'(i));
            end
            if (mem_wdata_o != v[127 - 8*i -: 8]) data_ok = 0;
            if (resv_kill_o) data_ok = 0;
        end
        chk(busy_ok, "R10", {tag, " busy and write in 16 cycles"}, 128'(busy_ok), 128'(1));
        chk(addr_ok, "R4", {tag, " byte addresses"}, 128'(addr_ok), 128'(1));
        chk(data_ok, "R5", {tag, " byte data order"}, 128'(data_ok), 128'(1));
        @(negedge clk);
        chk(done_o && !mem_we_o, "R8", {tag, " done after last byte"},
            128'({done_o, mem_we_o}), 128'(2'b10));
        chk(next_pc_o == pc + 32'd4, "R8", {tag, " next pc"}, 128'(next_pc_o), 128'(pc + 32'd4));
        @(negedge clk);
        chk(!done_o && ready_o && !mem_we_o, "R8", {tag, " done single pulse, idle"},
            128'({done_o, ready_o, mem_we_o}), 128'(3'b010));
        if (poke) begin
            @(negedge clk);
            chk(!mem_we_o && ready_o, "R10", {tag, " start while busy ignored"},
                128'({mem_we_o, ready_o}), 128'(2'b01));
        end
    endtask

    task automatic run_illegal(input logic [31:0] w, input string tag);
        @(negedge clk);
        start_i = 1'b1; instr_i = w;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk(illegal_o && ready_o && !mem_we_o && !resv_kill_o, "R9", {tag, " flag cycle"},
            128'({illegal_o, ready_o, mem_we_o, resv_kill_o}), 128'(4'b1100));
        @(negedge clk);
        chk(!illegal_o && !mem_we_o && !busy_o, "R9", {tag, " flag gone, no write"},
            128'({illegal_o, mem_we_o, busy_o}), 128'(0));
        @(negedge clk);
        chk(!mem_we_o && ready_o, "R9", {tag, " still idle"},
            128'({mem_we_o, ready_o}), 128'(2'b01));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(ready_o && !busy_o && !done_o && !illegal_o && !mem_we_o && !resv_kill_o,
            "R11", "reset state",
            128'({ready_o, busy_o, done_o, illegal_o, mem_we_o, resv_kill_o}), 128'(6'b100000));
    endtask

    task automatic t_basic;
        gpr[5] = 64'h1000_0000_0000_1234;
        gpr[6] = 64'h25;
        resv_en_i = 1'b0; resv_valid_i = 1'b1; resv_addr_i = 32'h0000_1250;
        run_store(enc_basic(3, 5, 6), 32'h0000_4000, 3, 32'h0000_1250, 1'b0, "R1 basic", 1'b0);
    endtask

    task automatic t_wide;
        gpr[7] = 64'hFFFF_FFFF_FFFF_FFF0;
        gpr[8] = 64'h20;
        resv_en_i = 1'b1; resv_valid_i = 1'b1; resv_addr_i = 32'h0000_001C;
        run_store(enc_wide(90, 7, 8), 32'h8000_0100, 90, 32'h0000_0010, 1'b1, "R2 wide wrap", 1'b0);
    endtask

    task automatic t_base_zero;
        gpr[0] = 64'hDEAD_0000;
        gpr[9] = 64'h0000_0000_ABCD_E00F;
        resv_en_i = 1'b1; resv_valid_i = 1'b1; resv_addr_i = 32'hABCD_E100;
        run_store(enc_basic(0, 0, 9), 32'h0000_0020, 0, 32'hABCD_E000, 1'b0, "R3 base zero", 1'b0);
    endtask

    task automatic t_no_resv;
        gpr[10] = 64'hFFFF_FFFF_0000_0400;
        gpr[11] = 64'h7;
        resv_en_i = 1'b1; resv_valid_i = 1'b0; resv_addr_i = 32'h0000_0400;
        run_store(enc_wide(127, 10, 11), 32'h0000_0200, 127, 32'h0000_0400, 1'b0, "R7 no resv", 1'b1);
    endtask

    task automatic t_illegal;
        run_illegal({6'd31, 5'd1, 5'd2, 5'd3, 10'd488, 1'b0}, "R9 basic xo");
        run_illegal({6'd4, 5'd1, 5'd2, 5'd3, 7'd61, 2'b00, 2'b00}, "R9 wide xo");
    endtask

    initial begin
        for (int i = 0; i < 32; i++) gpr[i] = 64'h0101_0101_0000_0000 * 64'(i + 1);
        for (int i = 0; i < 128; i++)
            vrf[i] = {4{32'(i * 32'h0101_0101 + 32'h0F1E_2D3C)}} ^ 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_wide();
        t_base_zero();
        t_no_resv();
        t_illegal();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule